// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers a set of maskable interrupt sources and one non-maskable input, and decides which request goes to the CPU. Each maskable source has a request flag, a 3-bit priority level and an edge polarity select. Each external input passes through a two-flop synchronizer and a minimum-width filter, and an accepted edge of the selected polarity sets the source's flag. The non-maskable input has its own longer width filter and latches a pending bit on a falling edge.

The CPU sees a single request line. This line is qualified by a global interrupt enable input, by the current processor priority level, and by a start-up hold that lasts until the first instruction after reset has completed. To acknowledge, the CPU reads a fixed location. That read returns one word holding the winning source number and level, and it clears the winner's flag as a side effect. The clear happens on any such read, including a read made while the request line is low. Software writes levels and polarities through a configuration port and writes request flags through a separate flag port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source with level 0 is never presented. A maskable winner raises `irq_req_o` only when `i_flag_i` is 1 and its level is strictly greater than `ipl_i`.
- R2: Among pending sources with a non-zero level, the highest level wins. Among equal levels, the lower source index wins.
- R3: The acknowledge word has the level in bits [ACK_W-1:ACK_W-3] and the source number in bits [IDX_W-1:0]. With the defaults it is 6 bits, level in [5:3] and number in [2:0]. A read made when nothing is pending returns 0. The word is valid on `ack_data_o` from the clock edge that samples `ack_rd_i`.
- R4: An acknowledge read clears the flag of the winner under R2, whatever the values of `i_flag_i` and `ipl_i`. Other flags are unchanged.
- R5: A falling edge on `nmi_n_i` sets a pending bit. This bit raises `irq_req_o` regardless of `i_flag_i` and `ipl_i`, and it beats every maskable source. Its acknowledge word is level 7 with number N_SRC (0x3E with the defaults), and that read clears the pending bit.
- R6: From reset until the first `insn_done_i` pulse, `irq_req_o` stays 0. This includes the case where the non-maskable bit is pending.
- R7: An external input counts only after it holds its new level for EXT_MIN_W consecutive clocks after synchronization. With polarity 1, a rising edge sets the flag. With polarity 0, a falling edge sets it.
- R8: The non-maskable input counts only after it holds its new level for NMI_MIN_W consecutive clocks. A shorter low pulse sets nothing.
- R9: A flag write stores `flag_val_i` into the selected flag. Switching a source's polarity while its input level matches the new active level sets its flag; a later write of 0 clears it.
- R10: When an accepted edge and a flag write of 0 reach the same flag on the same clock, the flag ends up set.
- R11: After reset, every level is 0, every polarity is 0, every flag is clear, nothing is pending, `ack_data_o` is 0 and `irq_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | N_SRC | External interrupt inputs, one per source |
| nmi_n_i | input | 1 | Non-maskable input, active on its falling edge |
| cfg_we_i | input | 1 | Write level and polarity of the selected source |
| cfg_sel_i | input | IDX_W | Source selected by a configuration write |
| cfg_lvl_i | input | 3 | Priority level to write |
| cfg_pol_i | input | 1 | Polarity to write (1 rising, 0 falling) |
| flag_we_i | input | 1 | Write the request flag of the selected source |
| flag_sel_i | input | IDX_W | Source selected by a flag write |
| flag_val_i | input | 1 | Flag value to write |
| i_flag_i | input | 1 | Global interrupt enable from the CPU |
| ipl_i | input | 3 | Current processor priority level |
| insn_done_i | input | 1 | Pulse when an instruction completes |
| ack_rd_i | input | 1 | Read of the acknowledge location |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| ack_data_o | output | ACK_W | Acknowledge word: level and source number |

## Verification
The hardest case to reach is an input edge arriving on the same clock as a software write of 0 to the same flag. The filter and synchronizer latency makes the edge from a pin hard to place on an exact cycle. The bench avoids that problem by using the polarity-switch effect as its edge source. It flips the polarity so that the flag is set exactly one clock after the configuration write, and it issues the clearing flag write on that same clock. It then confirms through an acknowledge read that the flag survived.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_OFF = 3'd0;
  localparam lvl_t LVL_NMI = 3'd7;

  // a level takes part in arbitration only when non-zero
  function automatic logic lvl_enabled(input lvl_t l);
    return l != LVL_OFF;
  endfunction

  // strict comparison against the processor priority level
  function automatic logic lvl_above(input lvl_t l, input lvl_t ipl);
    return l > ipl;
  endfunction

endpackage

// File: rtl/irq_pulse_filt.sv
module irq_pulse_filt #(
  parameter int  MIN_W   = 4,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic lvl_o
);

  localparam int CW = $clog2(MIN_W) + 1;

  logic          s1_q, s2_q, lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= RST_LVL;
      s2_q  <= RST_LVL;
      lvl_q <= RST_LVL;
      cnt_q <= '0;
    end else begin
      s1_q <= in_i;
      s2_q <= s1_q;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(MIN_W - 1)) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0]   flags_i,
  input  logic [3*N_SRC-1:0] lvls_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   id_o,
  output lvl_t               lvl_o
);

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    lvl_o   = LVL_OFF;
    // descending scan with >= lets the lower index win a tie
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (flags_i[i] && lvl_enabled(lvls_i[3*i +: 3]) &&
          (lvls_i[3*i +: 3] >= lvl_o)) begin
        valid_o = 1'b1;
        id_o    = IDX_W'(i);
        lvl_o   = lvls_i[3*i +: 3];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC     = 6,
  parameter int EXT_MIN_W = 4,
  parameter int NMI_MIN_W = 6,
  localparam int IDX_W    = $clog2(N_SRC + 1),
  localparam int ACK_W    = IDX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ext_irq_i,
  input  logic             nmi_n_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic [2:0]       cfg_lvl_i,
  input  logic             cfg_pol_i,
  input  logic             flag_we_i,
  input  logic [IDX_W-1:0] flag_sel_i,
  input  logic             flag_val_i,
  input  logic             i_flag_i,
  input  logic [2:0]       ipl_i,
  input  logic             insn_done_i,
  input  logic             ack_rd_i,
  output logic             irq_req_o,
  output logic [ACK_W-1:0] ack_data_o
);

  localparam logic [IDX_W-1:0] NMI_ID = IDX_W'(N_SRC);

  logic [3*N_SRC-1:0] lvl_q;
  logic [N_SRC-1:0]   pol_q;
  logic [N_SRC-1:0]   flag_q, flag_nx;
  logic [N_SRC-1:0]   filt_w, act_w, act_q, edge_w, ack_clr_w;
  logic               nmi_filt_w, nmi_filt_q, nmi_edge_w, nmi_pend_q;
  logic               go_q;
  logic               win_valid_w;
  logic [IDX_W-1:0]   win_id_w;
  lvl_t               win_lvl_w;
  logic [ACK_W-1:0]   ack_word_w, ack_data_q;

  // input conditioning, one filter per external source
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_pulse_filt #(.MIN_W(EXT_MIN_W), .RST_LVL(1'b0)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (ext_irq_i[i]),
      .lvl_o (filt_w[i])
    );
    assign act_w[i]     = pol_q[i] ? filt_w[i] : ~filt_w[i];
    assign edge_w[i]    = act_w[i] & ~act_q[i];
    assign ack_clr_w[i] = ack_rd_i & ~nmi_pend_q & win_valid_w &
                          (win_id_w == IDX_W'(i));
  end

  irq_pulse_filt #(.MIN_W(NMI_MIN_W), .RST_LVL(1'b1)) u_nmi_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (nmi_n_i),
    .lvl_o (nmi_filt_w)
  );
  assign nmi_edge_w = nmi_filt_q & ~nmi_filt_w;

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .flags_i (flag_q),
    .lvls_i  (lvl_q),
    .valid_o (win_valid_w),
    .id_o    (win_id_w),
    .lvl_o   (win_lvl_w)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      pol_q <= '0;
    end else if (cfg_we_i) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (cfg_sel_i == IDX_W'(i)) begin
          lvl_q[3*i +: 3] <= cfg_lvl_i;
          pol_q[i]        <= cfg_pol_i;
        end
      end
    end
  end

  // flag update: edge beats a software write, write beats an ack clear
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      if (edge_w[i])
        flag_nx[i] = 1'b1;
      else if (flag_we_i && (flag_sel_i == IDX_W'(i)))
        flag_nx[i] = flag_val_i;
      else if (ack_clr_w[i])
        flag_nx[i] = 1'b0;
      else
        flag_nx[i] = flag_q[i];
    end
  end

  always_comb begin
    if (nmi_pend_q)
      ack_word_w = {LVL_NMI, NMI_ID};
    else if (win_valid_w)
      ack_word_w = {win_lvl_w, win_id_w};
    else
      ack_word_w = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      act_q      <= '1;
      nmi_filt_q <= 1'b1;
      nmi_pend_q <= 1'b0;
      go_q       <= 1'b0;
      ack_data_q <= '0;
    end else begin
      flag_q     <= flag_nx;
      act_q      <= act_w;
      nmi_filt_q <= nmi_filt_w;
      if (nmi_edge_w)
        nmi_pend_q <= 1'b1;
      else if (ack_rd_i && nmi_pend_q)
        nmi_pend_q <= 1'b0;
      if (insn_done_i)
        go_q <= 1'b1;
      if (ack_rd_i)
        ack_data_q <= ack_word_w;
    end
  end

  assign irq_req_o  = go_q & (nmi_pend_q |
                      (i_flag_i & win_valid_w & lvl_above(win_lvl_w, ipl_i)));
  assign ack_data_o = ack_data_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int N_SRC = 6,
  parameter int IDX_W = 3,
  parameter int ACK_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_flag_i,
  input logic             flag_we_i,
  input logic             ack_rd_i,
  input logic             irq_req_o,
  input logic [ACK_W-1:0] ack_data_o,
  input logic [N_SRC-1:0] flag_q,
  input logic [N_SRC-1:0] edge_w,
  input logic             nmi_edge_w,
  input logic             nmi_pend_q,
  input logic             go_q,
  input logic             win_valid_w
);

  localparam logic [ACK_W-1:0] NMI_WORD = {3'd7, IDX_W'(N_SRC)};

  // R6: nothing reaches the CPU before the first instruction completes
  p_hold_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |-> !irq_req_o);

  // R5: a pending non-maskable request is always presented once running
  p_nmi_unmaskable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && nmi_pend_q) |-> irq_req_o);

  // R5: acknowledge of the non-maskable request returns its fixed word
  p_nmi_ack_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && nmi_pend_q) |=> (ack_data_o == NMI_WORD));

  // R5: acknowledge clears the non-maskable pending bit
  p_nmi_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && nmi_pend_q && !nmi_edge_w) |=> !nmi_pend_q);

  // R1: a maskable request needs the global enable
  p_mask_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !nmi_pend_q) |-> i_flag_i);

  // R4: an acknowledge read clears exactly one flag when one is eligible
  p_ack_clears_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd_i && !nmi_pend_q && !flag_we_i && (edge_w == '0)) |=>
      ($countones(flag_q) + ($past(win_valid_w) ? 1 : 0) ==
       $countones($past(flag_q))));

  // R10: an accepted edge always leaves its flag set
  for (genvar i = 0; i < N_SRC; i++) begin : g_edge
    p_edge_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_w[i] |=> flag_q[i]);
  end

endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ACK_W(ACK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .i_flag_i    (i_flag_i),
  .flag_we_i   (flag_we_i),
  .ack_rd_i    (ack_rd_i),
  .irq_req_o   (irq_req_o),
  .ack_data_o  (ack_data_o),
  .flag_q      (flag_q),
  .edge_w      (edge_w),
  .nmi_edge_w  (nmi_edge_w),
  .nmi_pend_q  (nmi_pend_q),
  .go_q        (go_q),
  .win_valid_w (win_valid_w)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

  localparam int N = 6;
  localparam int IW = 3;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ext_irq = '0;
  logic          nmi_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [2:0]    cfg_lvl = '0;
  logic          cfg_pol = 1'b0;
  logic          flag_we = 1'b0;
  logic [IW-1:0] flag_sel = '0;
  logic          flag_val = 1'b0;
  logic          i_flag = 1'b0;
  logic [2:0]    ipl = '0;
  logic          insn_done = 1'b0;
  logic          ack_rd = 1'b0;
  logic          irq_req;
  logic [AW-1:0] ack_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N), .EXT_MIN_W(4), .NMI_MIN_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .nmi_n_i(nmi_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_lvl_i(cfg_lvl), .cfg_pol_i(cfg_pol),
    .flag_we_i(flag_we), .flag_sel_i(flag_sel), .flag_val_i(flag_val),
    .i_flag_i(i_flag), .ipl_i(ipl), .insn_done_i(insn_done), .ack_rd_i(ack_rd),
    .irq_req_o(irq_req), .ack_data_o(ack_data)
  );

  typedef struct packed {
    logic [17:0] lvls;   // src5 .. src0, 3 bits each
    logic [5:0]  flags;
    logic        ien;
    logic [2:0]  ipl;
    logic        req;
    logic [5:0]  ack;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{lvls: {3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, flags: 6'b000101, ien: 1'b1, ipl: 3'd0, req: 1'b1, ack: 6'd26},
    '{lvls: {3'd6,3'd5,3'd4,3'd3,3'd2,3'd1}, flags: 6'b111111, ien: 1'b1, ipl: 3'd6, req: 1'b0, ack: 6'd53},
    '{lvls: {3'd0,3'd0,3'd0,3'd3,3'd3,3'd3}, flags: 6'b000110, ien: 1'b1, ipl: 3'd2, req: 1'b1, ack: 6'd25},
    '{lvls: {3'd7,3'd0,3'd0,3'd0,3'd0,3'd0}, flags: 6'b011111, ien: 1'b1, ipl: 3'd0, req: 1'b0, ack: 6'd0},
    '{lvls: {3'd7,3'd7,3'd7,3'd7,3'd7,3'd7}, flags: 6'b100000, ien: 1'b0, ipl: 3'd0, req: 1'b0, ack: 6'd61},
    '{lvls: {3'd4,3'd4,3'd1,3'd5,3'd5,3'd2}, flags: 6'b110010, ien: 1'b1, ipl: 3'd4, req: 1'b1, ack: 6'd41}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int sel, input int lvl, input logic pol);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = IW'(sel); cfg_lvl = 3'(lvl); cfg_pol = pol;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wflag(input int sel, input logic val);
    @(negedge clk);
    flag_we = 1'b1; flag_sel = IW'(sel); flag_val = val;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic ack(output logic [AW-1:0] w);
    @(negedge clk);
    ack_rd = 1'b1;
    @(negedge clk);
    ack_rd = 1'b0;
    w = ack_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    insn_done = 1'b0; i_flag = 1'b0; ipl = '0; nmi_n = 1'b1; ext_irq = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] w;

    do_reset();
    // R11 reset state
    chk("R11 req after reset", int'(irq_req), 0);
    chk("R11 ack_data after reset", int'(ack_data), 0);

    // R6 start-up hold
    cfg(0, 5, 1'b0);
    wflag(0, 1'b1);
    i_flag = 1'b1; ipl = 3'd0;
    cyc(2);
    chk("R6 req held before first insn", int'(irq_req), 0);
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
    chk("R6 req after first insn", int'(irq_req), 1);
    ack(w);
    chk("R3 ack word src0 lvl5", int'(w), 40);
    chk("R4 req drops after ack", int'(irq_req), 0);

    // R5 non-maskable ignores enable
    i_flag = 1'b0;
    @(negedge clk); nmi_n = 1'b0;
    cyc(10); nmi_n = 1'b1;
    cyc(20);
    chk("R5 nmi req with enable off", int'(irq_req), 1);
    ack(w);
    chk("R5 nmi ack word", int'(w), 62);
    chk("R5 nmi cleared by ack", int'(irq_req), 0);

    // R8 short nmi pulse rejected
    @(negedge clk); nmi_n = 1'b0;
    cyc(3); nmi_n = 1'b1;
    cyc(20);
    chk("R8 short nmi pulse req", int'(irq_req), 0);
    ack(w);
    chk("R8 short nmi pulse ack", int'(w), 0);

    // table of arbitration vectors (R1 R2 R3 R4)
    for (int v = 0; v < 6; v++) begin
      for (int s = 0; s < N; s++) cfg(s, int'(TBL[v].lvls[3*s +: 3]), 1'b0);
      for (int s = 0; s < N; s++) wflag(s, TBL[v].flags[s]);
      i_flag = TBL[v].ien; ipl = TBL[v].ipl;
      cyc(1);
      chk($sformatf("R1 vector %0d req", v), int'(irq_req), int'(TBL[v].req));
      ack(w);
      chk($sformatf("R2 vector %0d ack", v), int'(w), int'(TBL[v].ack));
      for (int s = 0; s < N; s++) wflag(s, 1'b0);
    end
    for (int s = 0; s < N; s++) cfg(s, 0, 1'b0);

    // R4 successive acks clear one flag each
    cfg(0, 1, 1'b0); cfg(1, 2, 1'b0);
    wflag(0, 1'b1); wflag(1, 1'b1);
    ack(w); chk("R4 first ack", int'(w), 17);
    ack(w); chk("R4 second ack", int'(w), 8);
    ack(w); chk("R4 third ack empty", int'(w), 0);
    cfg(0, 0, 1'b0); cfg(1, 0, 1'b0);

    // R7 rising edge with width filter on src3
    cfg(3, 2, 1'b1);
    @(negedge clk); ext_irq[3] = 1'b1;
    cyc(12);
    ack(w); chk("R7 long rising pulse sets flag", int'(w), 19);
    ext_irq[3] = 1'b0;
    cyc(12);
    ack(w); chk("R7 falling edge ignored with pol 1", int'(w), 0);
    @(negedge clk); ext_irq[3] = 1'b1;
    cyc(2); ext_irq[3] = 1'b0;
    cyc(12);
    ack(w); chk("R7 short pulse rejected", int'(w), 0);

    // R9 polarity switch sets flag spuriously (src4 input stays low)
    cfg(4, 3, 1'b1);
    cyc(2);
    ack(w); chk("R9 pol to rising no flag", int'(w), 0);
    cfg(4, 3, 1'b0);
    cyc(1);
    ack(w); chk("R9 pol to falling sets flag", int'(w), 28);

    // R10 edge and write 0 in the same cycle
    cfg(4, 3, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = IW'(4); cfg_lvl = 3'd3; cfg_pol = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    flag_we = 1'b1; flag_sel = IW'(4); flag_val = 1'b0;
    @(negedge clk);
    flag_we = 1'b0;
    cyc(1);
    ack(w); chk("R10 edge beats write 0", int'(w), 28);

    // R9 software write 1 then 0
    wflag(4, 1'b1);
    wflag(4, 1'b0);
    ack(w); chk("R9 write 0 clears flag", int'(w), 0);

    // R6 non-maskable held after a fresh reset
    do_reset();
    chk("R11 req after second reset", int'(irq_req), 0);
    @(negedge clk); nmi_n = 1'b0;
    cyc(10); nmi_n = 1'b1;
    cyc(20);
    chk("R6 nmi held before first insn", int'(irq_req), 0);
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
    chk("R6 nmi presented after first insn", int'(irq_req), 1);
    ack(w); chk("R5 nmi ack after hold", int'(w), 62);

    finish_run();
  end

endmodule